// File: doc/BRIEF.md
# Short-Circuit Protection Sequencer

This block is the digital control core of a single gate-driver channel. It passes a PWM-derived gate command to the gate pull-up while conditions are normal. It watches a desaturation / over-current comparator that arrives as a digital input. After every turn-on the comparator is masked for a programmable blanking time. Once blanking ends, a programmable count of consecutive assertions is needed before a fault is accepted.

An accepted fault never slams the gate. It first drives a strong pull-down for a programmable time, then a weak pull-down for a programmable tail time. After that the gate is held off by a clamp. From there, one of two policies applies. Under the latch policy the block stays off until a clear request arrives while the comparator is quiet. Under the retry policy it waits a programmable cooldown and re-enables, up to a programmable number of times, then latches for good.

The active-low fault output is low for the whole fault episode. An off-confirmation output rises only when a gate-below-safe-voltage input is seen during the fault, or when the latched state is reached. A latency output reports how many fault cycles elapsed before that confirmation.

Top module: `gd_scp_sequencer`

## Requirements
- R1: After reset, `flt_n` is 1, `drv_fast`, `drv_soft`, `drv_clamp` and `off_ok` are 0, and `lat_cycles` is 0.
- R2: In normal operation `drv_on` equals `gate_cmd`. While `flt_n` is 0, `drv_on` is 0 whatever `gate_cmd` does. At most one of `drv_on`, `drv_fast`, `drv_soft`, `drv_clamp` is 1 at any time.
- R3: The cycle in which `drv_on` rises is blanking cycle 0. The comparator is ignored for `cfg_blank` cycles counted from there.
- R4: After blanking, a fault is accepted on the `max(cfg_filt,1)`-th consecutive high comparator sample taken while `drv_on` is 1. A low sample restarts the count. `flt_n` falls in the following cycle. With the comparator held high from turn-on, `flt_n` falls `cfg_blank + max(cfg_filt,1)` clock edges after `drv_on` rises.
- R5: On fault entry, `drv_fast` is 1 for exactly `max(cfg_fast,1)` cycles. `drv_soft` is then 1 for exactly `max(cfg_soft,1)` cycles, after which `drv_clamp` holds the gate off.
- R6: `flt_n` stays 0 without interruption from the first fast cycle until the block returns to normal operation.
- R7: With `policy_retry`=0 the block stays latched after the tail. `clear_req` is ignored while `desat_in` is 1. When `clear_req` is 1 and `desat_in` is 0, normal operation resumes on the next clock edge.
- R8: With `policy_retry`=1, each tail is followed by `max(cfg_cool,1)` clamp cycles and then a re-enable. This repeats at most `cfg_max_retry` times in total, after which the block latches as in R7. With `cfg_max_retry`=0 it latches at once.
- R9: `off_ok` is 1 only during a fault episode. It is 1 when `gate_safe` is 1 or when the latched state is reached, and 0 otherwise.
- R10: `lat_cycles` captures the index of the first fault cycle with `off_ok`=1, where the first fast cycle has index 0. The value appears on the following edge and is held outside fault episodes.
- R11: Leaving the latched state through `clear_req` restores the full retry allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_cmd | input | 1 | PWM-derived gate-on request |
| desat_in | input | 1 | Desaturation / over-current comparator, high = overload |
| gate_safe | input | 1 | High when the gate is below the safe-off voltage |
| policy_retry | input | 1 | 0 = latch policy, 1 = bounded retry policy |
| clear_req | input | 1 | Request to leave the latched state |
| cfg_blank | input | CW | Blanking length in cycles |
| cfg_filt | input | CW | Consecutive samples needed to accept a fault |
| cfg_fast | input | CW | Strong pull-down phase length |
| cfg_soft | input | CW | Weak pull-down tail length |
| cfg_cool | input | CW | Cooldown length before a retry |
| cfg_max_retry | input | RW | Maximum number of re-enables |
| drv_on | output | 1 | Gate pull-up enable |
| drv_fast | output | 1 | Strong pull-down enable |
| drv_soft | output | 1 | Weak pull-down enable |
| drv_clamp | output | 1 | Off-state gate clamp enable |
| flt_n | output | 1 | Active-low fault report |
| off_ok | output | 1 | Gate-off confirmation |
| lat_cycles | output | LW | Fault cycles from entry to confirmation |

## Verification
The hardest state to reach from the ports is the permanent latch that follows an exhausted retry budget. It needs a whole chain of turn-on, blanking, filtering, fast phase, tail and cooldown to run through several times with the comparator still high. The stimulus holds both the gate command and the comparator high under the retry policy and counts rising edges of the fault output over a window long enough for every attempt. It then releases the latch with a clear request and repeats the run to show that the allowance came back. A sweep over small blanking and filter lengths, with the comparator held high from turn-on, pins the exact acceptance cycle for each pair.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_FAST  = 3'd1,
      ST_SOFT  = 3'd2,
      ST_COOL  = 3'd3,
      ST_LATCH = 3'd4
   } scp_state_t;
endpackage

// File: rtl/scp_qualify.sv
// Blanking after turn-on plus consecutive-sample filter for the comparator.
module scp_qualify #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          on,
   input  logic          desat,
   input  logic [CW-1:0] blank_len,
   input  logic [CW-1:0] filt_len,
   output logic          blanking,
   output logic          qualify
);
   localparam logic [CW-1:0] SAT = '1;

   logic [CW-1:0] age_q;   // cycles since the gate turned on, saturating
   logic [CW-1:0] run_q;   // consecutive high samples after blanking

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (!on)          age_q <= '0;
      else if (age_q != SAT) age_q <= age_q + 1'b1;
   end

   assign blanking = on && (age_q < blank_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       run_q <= '0;
      else if (!on || blanking || !desat) run_q <= '0;
      else if (run_q != SAT)            run_q <= run_q + 1'b1;
   end

   assign qualify = on && !blanking && desat &&
                    (({1'b0, run_q} + 1'b1) >= {1'b0, filt_len});
endmodule

// File: rtl/scp_phase_timer.sv
// Shared phase timer: restarts on every state change, flags the last cycle.
module scp_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [CW-1:0] len,
   output logic          done
);
   localparam logic [CW-1:0] SAT = '1;

   logic [CW-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ph_q <= '0;
      else if (restart)     ph_q <= '0;
      else if (ph_q != SAT) ph_q <= ph_q + 1'b1;
   end

   // a length of zero behaves as one cycle
   assign done = (({1'b0, ph_q} + 1'b1) >= {1'b0, len});
endmodule

// File: rtl/gd_scp_sequencer.sv
module gd_scp_sequencer
   import scp_pkg::*;
#(
   parameter int CW          = 8,
   parameter int RW          = 3,
   parameter int LW          = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_cmd,
   input  logic          desat_in,
   input  logic          gate_safe,
   input  logic          policy_retry,
   input  logic          clear_req,
   input  logic [CW-1:0] cfg_blank,
   input  logic [CW-1:0] cfg_filt,
   input  logic [CW-1:0] cfg_fast,
   input  logic [CW-1:0] cfg_soft,
   input  logic [CW-1:0] cfg_cool,
   input  logic [RW-1:0] cfg_max_retry,
   output logic          drv_on,
   output logic          drv_fast,
   output logic          drv_soft,
   output logic          drv_clamp,
   output logic          flt_n,
   output logic          off_ok,
   output logic [LW-1:0] lat_cycles
);
   localparam logic [LW-1:0] LAT_SAT = '1;

   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("CW must lie in 2..16");
   end
   if (RW < 1 || RW > 8) begin : g_bad_rw
      $error("RW must lie in 1..8");
   end
   if (LW < CW + 1) begin : g_bad_lw
      $error("LW must exceed CW");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   // optional comparator synchronizer
   logic desat_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign desat_s = desat_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else begin
            sh_q[0] <= desat_in;
            for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
         end
      end
      assign desat_s = sh_q[SYNC_STAGES-1];
   end

   scp_state_t    st_q, st_d;
   logic [RW-1:0] retry_q;
   logic          qual, blanking, ph_done;
   logic [CW-1:0] ph_len;

   assign drv_on    = (st_q == ST_RUN) && gate_cmd;
   assign drv_fast  = (st_q == ST_FAST);
   assign drv_soft  = (st_q == ST_SOFT);
   assign drv_clamp = (st_q == ST_COOL) || (st_q == ST_LATCH);
   assign flt_n     = (st_q == ST_RUN);
   assign off_ok    = !flt_n && (gate_safe || (st_q == ST_LATCH));

   scp_qualify #(.CW(CW)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .on        (drv_on),
      .desat     (desat_s),
      .blank_len (cfg_blank),
      .filt_len  (cfg_filt),
      .blanking  (blanking),
      .qualify   (qual)
   );

   always_comb begin
      case (st_q)
         ST_FAST: ph_len = cfg_fast;
         ST_SOFT: ph_len = cfg_soft;
         ST_COOL: ph_len = cfg_cool;
         default: ph_len = '0;
      endcase
   end

   scp_phase_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st_d != st_q),
      .len     (ph_len),
      .done    (ph_done)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:   if (qual) st_d = ST_FAST;
         ST_FAST:  if (ph_done) st_d = ST_SOFT;
         ST_SOFT:  if (ph_done)
                      st_d = (policy_retry && (retry_q < cfg_max_retry)) ? ST_COOL : ST_LATCH;
         ST_COOL:  if (ph_done) st_d = ST_RUN;
         ST_LATCH: if (clear_req && !desat_s) st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         retry_q <= '0;
      end else begin
         st_q <= st_d;
         if ((st_q == ST_LATCH) && (st_d == ST_RUN))     retry_q <= '0;
         else if ((st_q == ST_COOL) && (st_d == ST_RUN)) retry_q <= retry_q + 1'b1;
      end
   end

   // detect-to-confirm latency, captured once per fault episode
   logic [LW-1:0] cnt_q;
   logic          cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cap_q      <= 1'b0;
         lat_cycles <= '0;
      end else if ((st_q == ST_RUN) && qual) begin
         cnt_q <= '0;
         cap_q <= 1'b0;
      end else if ((st_q != ST_RUN) && !cap_q) begin
         if (cnt_q != LAT_SAT) cnt_q <= cnt_q + 1'b1;
         if (off_ok) begin
            lat_cycles <= cnt_q;
            cap_q      <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/scp_sequencer_chk.sv
module scp_sequencer_chk #(
   parameter int LW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          drv_on,
   input logic          drv_fast,
   input logic          drv_soft,
   input logic          drv_clamp,
   input logic          flt_n,
   input logic          off_ok,
   input logic [LW-1:0] lat_cycles
);
   assert_one_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_on, drv_fast, drv_soft, drv_clamp}));

   assert_fault_after_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_n) |-> $past(drv_on));

   assert_entry_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_n) |-> drv_fast);

   assert_fast_then_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_fast) |-> drv_soft);

   assert_exit_from_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_n) |-> $past(drv_clamp));

   assert_confirm_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      off_ok |-> !flt_n);

   assert_latency_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_n && $past(flt_n)) |-> $stable(lat_cycles));
endmodule

bind gd_scp_sequencer scp_sequencer_chk #(.LW(LW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .drv_on     (drv_on),
   .drv_fast   (drv_fast),
   .drv_soft   (drv_soft),
   .drv_clamp  (drv_clamp),
   .flt_n      (flt_n),
   .off_ok     (off_ok),
   .lat_cycles (lat_cycles)
);

// File: tb/sim_gd_scp_sequencer.sv
`timescale 1ns/1ps
module sim_gd_scp_sequencer;
   localparam int CW = 4;
   localparam int RW = 2;
   localparam int LW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_cmd = 1'b0, desat_in = 1'b0, gate_safe = 1'b0;
   logic policy_retry = 1'b0, clear_req = 1'b0;
   logic [CW-1:0] cfg_blank = '0, cfg_filt = 4'd1, cfg_fast = 4'd1;
   logic [CW-1:0] cfg_soft = 4'd1, cfg_cool = 4'd1;
   logic [RW-1:0] cfg_max_retry = '0;
   logic drv_on, drv_fast, drv_soft, drv_clamp, flt_n, off_ok;
   logic [LW-1:0] lat_cycles;

   int nchk = 0, nfail = 0, ncyc = 0;

   always #10 clk = ~clk;

   gd_scp_sequencer #(.CW(CW), .RW(RW), .LW(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .desat_in(desat_in),
      .gate_safe(gate_safe), .policy_retry(policy_retry), .clear_req(clear_req),
      .cfg_blank(cfg_blank), .cfg_filt(cfg_filt), .cfg_fast(cfg_fast),
      .cfg_soft(cfg_soft), .cfg_cool(cfg_cool), .cfg_max_retry(cfg_max_retry),
      .drv_on(drv_on), .drv_fast(drv_fast), .drv_soft(drv_soft),
      .drv_clamp(drv_clamp), .flt_n(flt_n), .off_ok(off_ok),
      .lat_cycles(lat_cycles));

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
   endtask

   always @(posedge clk) begin
      ncyc++;
      if (ncyc > 100000) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual=%0d cycles expected below 100000", ncyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; gate_cmd = 0; desat_in = 0; gate_safe = 0; clear_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int mx1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   // counts re-enables over a window; returns clamp cycles before the first
   task automatic run_retry(output int reen, output int first_cool, output int bad_on);
      int prev = 1, clamp_run = 0;
      reen = 0; first_cool = -1; bad_on = 0;
      for (int i = 0; i < 120; i++) begin
         tick();
         if (drv_on && !flt_n) bad_on++;
         if (drv_clamp && reen == 0) clamp_run++;
         if (prev == 0 && flt_n) begin
            reen++;
            if (first_cool < 0) first_cool = clamp_run;
         end
         prev = flt_n;
      end
   endtask

   initial begin
      int edges, cf, cs, reen, fc, bad;
      do_reset();
      // R1 reset state
      chk("R1 flt_n", flt_n, 1);
      chk("R1 drivers", {drv_fast, drv_soft, drv_clamp}, 0);
      chk("R1 off_ok", off_ok, 0);
      chk("R1 lat_cycles", lat_cycles, 0);
      chk("R2 drv_on low", drv_on, 0);
      gate_cmd = 1; #1;
      chk("R2 drv_on follows", drv_on, 1);
      gate_cmd = 0;

      // R3/R4 sweep of acceptance cycle
      for (int b = 0; b < 4; b++) begin
         for (int f = 0; f < 4; f++) begin
            do_reset();
            cfg_blank = b[CW-1:0]; cfg_filt = f[CW-1:0];
            desat_in = 1; gate_cmd = 1;
            edges = 0;
            for (int e = 0; e < 30; e++) begin
               tick(); edges++;
               if (!flt_n) break;
            end
            chk($sformatf("R4 accept edge b=%0d f=%0d", b, f), edges, b + mx1(f));
         end
      end

      // R3 comparator high only inside blanking plus one short sample
      do_reset();
      cfg_blank = 3; cfg_filt = 2; desat_in = 1; gate_cmd = 1;
      for (int e = 0; e < 12; e++) begin
         desat_in = (e < 4);
         tick();
      end
      chk("R3 blanked pulse ignored", flt_n, 1);

      // R4 low sample restarts the filter
      do_reset();
      cfg_blank = 2; cfg_filt = 3; gate_cmd = 1;
      for (int e = 0; e < 8; e++) begin
         desat_in = (8'b1110_1100 >> e) & 1;
         tick();
         if (e == 6) chk("R4 restart no fault yet", flt_n, 1);
         if (e == 7) chk("R4 restart fault", flt_n, 0);
      end

      // R5/R6 two-level turn-off lengths
      foreach (cf_set[i]) begin end
      for (int fa = 0; fa < 4; fa++) begin
         for (int so = 1; so < 5; so += 3) begin
            do_reset();
            cfg_blank = 0; cfg_filt = 1; policy_retry = 0;
            cfg_fast = fa[CW-1:0]; cfg_soft = so[CW-1:0];
            desat_in = 1; gate_cmd = 1;
            tick();
            cf = 0; cs = 0;
            while (drv_fast && cf < 20) begin cf++; tick(); end
            while (drv_soft && cs < 20) begin
               cs++;
               if (flt_n) chk("R6 flt_n steady", flt_n, 0);
               tick();
            end
            chk($sformatf("R5 fast len %0d", fa), cf, mx1(fa));
            chk($sformatf("R5 soft len %0d", so), cs, so);
            chk("R5 clamp after tail", drv_clamp, 1);
         end
      end

      // R9/R10 confirmation by gate_safe after k cycles
      for (int k = 0; k < 4; k++) begin
         do_reset();
         cfg_blank = 0; cfg_filt = 1; cfg_fast = 2; cfg_soft = 3; policy_retry = 0;
         desat_in = 1; gate_cmd = 1;
         tick();
         for (int j = 0; j < k; j++) begin
            chk("R9 no confirm without gate_safe", off_ok, 0);
            tick();
         end
         gate_safe = 1; #1;
         chk("R9 confirm on gate_safe", off_ok, 1);
         tick();
         chk($sformatf("R10 latency k=%0d", k), lat_cycles, k);
      end

      // R9/R10 confirmation by reaching the latch, then R7 clear rules
      do_reset();
      cfg_blank = 0; cfg_filt = 1; cfg_fast = 2; cfg_soft = 3; policy_retry = 0;
      desat_in = 1; gate_cmd = 1;
      tick();
      repeat (6) tick();
      chk("R9 confirm in latch", off_ok, 1);
      chk("R10 latency at latch", lat_cycles, 5);
      repeat (10) tick();
      chk("R7 still latched", flt_n, 0);
      chk("R2 drv_on blocked", drv_on, 0);
      clear_req = 1; tick(); tick();
      chk("R7 clear ignored with desat", flt_n, 0);
      desat_in = 0; tick();
      chk("R7 clear restores", flt_n, 1);
      chk("R2 drv_on after clear", drv_on, 1);
      clear_req = 0; tick();
      chk("R10 latency held", lat_cycles, 5);

      // R8 bounded retry
      do_reset();
      policy_retry = 1; cfg_max_retry = 2; cfg_cool = 3;
      cfg_fast = 1; cfg_soft = 1; cfg_blank = 1; cfg_filt = 1;
      desat_in = 1; gate_cmd = 1;
      run_retry(reen, fc, bad);
      chk("R8 re-enable count", reen, 2);
      chk("R8 cooldown length", fc, 3);
      chk("R2 no drive in fault", bad, 0);
      chk("R8 latched after budget", drv_clamp, 1);
      chk("R8 fault held", flt_n, 0);

      // R7/R11 clear after exhausted budget restores allowance
      clear_req = 1; tick(); tick();
      chk("R7 clear ignored with desat", flt_n, 0);
      desat_in = 0; tick();
      chk("R7 clear restores", flt_n, 1);
      clear_req = 0; desat_in = 1;
      run_retry(reen, fc, bad);
      chk("R11 allowance restored", reen, 2);

      // R8 zero retry budget latches at once
      do_reset();
      policy_retry = 1; cfg_max_retry = 0;
      desat_in = 1; gate_cmd = 1;
      run_retry(reen, fc, bad);
      chk("R8 zero budget re-enables", reen, 0);
      chk("R8 zero budget latched", drv_clamp, 1);

      summary();
      $finish;
   end

   int cf_set[1];
endmodule